// File: doc/BRIEF.md
# Line-Change Interrupt Latch with Alert-Response Arbitration

This block watches a group of general-purpose I/O lines and flags the bus master when one of them changes. Each line goes through a two-stage synchroniser and is then compared with its value one cycle earlier, so that a rising or falling transition is seen. A rise mask and a fall mask, each one bit per line, choose which transitions count. Any transition that is not masked sets a sticky pending flag. A separate fault input, which no mask can block, also sets the flag. While the flag is set, the active-low open-drain alert output is pulled low.

The master finds out who raised the alert by reading from the shared alert-response address. The serial shifter sits outside this block. It decodes that read and, in the SCL-low phase that follows its acknowledge, gives the block a one-cycle go pulse. If the block has an interrupt pending, it then places its own seven-bit address, followed by a released trailing bit, onto SDA, most significant bit first. On every rising SCL edge it checks the bus for a lost arbitration. The flag is cleared only when the whole byte goes out without a loss, or when software reset is pulsed. Setting a mask bit after the fact does not clear it. A fault that is still present sets the flag again at once.

The reset is asynchronous and active low, and it is expected to be released synchronously to `clk`. `scl_i` and `sda_i` are the bus levels, already synchronised by the shifter.

Top module: `edge_alert_unit`

## Requirements
- R1: While reset is held and just after it is released, `alert_n_o` is 1 and `sda_low_o` is 0.
- R2: Take a line whose rise-mask bit is 0 (0 = enabled, 1 = masked). It is first sampled high at clock edge k after being low. `alert_n_o` then reads 1 after edges k and k+1, and 0 after edge k+2.
- R3: A high-to-low change on a line whose fall-mask bit is 0 sets the flag with the same latency as R2.
- R4: A transition whose mask bit for that direction is 1 leaves `alert_n_o` unchanged. A line with both mask bits at 0 flags both directions.
- R5: A level that is sampled on a single clock edge and then returns sets the flag.
- R6: Once the flag is set it stays set whatever the masks do, until software reset or a won alert-response byte clears it.
- R7: While `fault_i` is 1 the flag is set on every cycle, regardless of the masks. A clear applied during that time leaves `alert_n_o` at 0.
- R8: A `sw_reset_i` pulse clears the flag: `alert_n_o` is 1 after the edge that samples the pulse.
- R9: A go pulse seen while the flag is set starts a byte of {address[6:0], 1}, sent most significant bit first. `sda_low_o` is 1 exactly for the 0 bits. It changes only while SCL is low, one cycle after each SCL fall is seen.
- R10: Suppose the block sends a 1 and samples SDA low on a rising SCL edge. It then drives nothing more for the rest of that byte, and the flag stays set.
- R11: When the eighth SCL fall of a byte comes without a loss, `alert_n_o` returns to 1 two cycles later.
- R12: A go pulse seen while no interrupt is pending leaves `sda_low_o` at 0 for the whole transfer.
- R13: When an interrupt arrives in the same cycle as a clear, the interrupt wins and `alert_n_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Monitored I/O levels, asynchronous |
| rise_mask_i | input | 8 | 1 masks the low-to-high interrupt of the line |
| fall_mask_i | input | 8 | 1 masks the high-to-low interrupt of the line |
| fault_i | input | 1 | Fault condition that cannot be masked, level |
| sw_reset_i | input | 1 | Software reset pulse, clears the flag |
| own_addr_i | input | 7 | Address returned during alert response |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| ara_go_i | input | 1 | One-cycle pulse: alert-response data byte begins |
| alert_n_o | output | 1 | Alert, 0 = asserted (open-drain pull) |
| sda_low_o | output | 1 | 1 = pull SDA low |

## Verification
The setting and clearing of the pending flag can fall on the same clock edge. This happens when a line transition or a live fault coincides with a software-reset pulse, or with the clear that follows a won alert-response byte. The bench lines up a line change so that its transition reaches the latch on exactly the edge that samples `sw_reset_i`. It also runs a complete alert-response byte while the fault is held high. In both cases `alert_n_o` is judged against a behavioural reference model on every cycle, and directed checks confirm that the alert stays low.

// File: rtl/eia_pkg.sv
package eia_pkg;
  // Alert-response transmitter states
  typedef enum logic [0:0] {
    ARA_IDLE = 1'b0,
    ARA_SEND = 1'b1
  } ara_state_e;

  localparam int unsigned ADDR_W = 7;
endpackage

// File: rtl/eia_edge_detect.sv
module eia_edge_detect #(
  parameter int unsigned N    = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int unsigned FILL_MAX = SYNC + 1;
  localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

  logic [SYNC-1:0][N-1:0] sync_q, sync_d;
  logic [N-1:0]           prev_q;
  logic [FILL_W-1:0]      fill_q, fill_d;
  logic                   armed;

  // edges are suppressed until synchroniser and history hold real samples
  assign armed = (fill_q == FILL_W'(FILL_MAX));

  always_comb begin
    sync_d[0] = line_i;
    for (int s = 1; s < int'(SYNC); s++) begin
      sync_d[s] = sync_q[s-1];
    end
    fill_d = armed ? fill_q : FILL_W'(fill_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC-1];
      fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_line
    assign rise_o[g] = armed &  sync_q[SYNC-1][g] & ~prev_q[g];
    assign fall_o[g] = armed & ~sync_q[SYNC-1][g] &  prev_q[g];
  end
endmodule

// File: rtl/eia_irq_latch.sv
module eia_irq_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] rise_mask_i,
  input  logic [N-1:0] fall_mask_i,
  input  logic         fault_i,
  input  logic         clr_sw_i,
  input  logic         clr_win_i,
  output logic         set_o,
  output logic         pend_o
);
  logic pend_q, pend_d;

  assign set_o = fault_i
               | (|(rise_i & ~rise_mask_i))
               | (|(fall_i & ~fall_mask_i));

  // set has priority: a live source is never lost to a clear
  always_comb begin
    pend_d = pend_q;
    if (set_o) begin
      pend_d = 1'b1;
    end else if (clr_sw_i || clr_win_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/eia_ara_tx.sv
module eia_ara_tx
  import eia_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          go_i,
  input  logic          pend_i,
  input  logic [AW-1:0] addr_i,
  output logic          sda_low_o,
  output logic          win_o,
  output logic          busy_o,
  output logic          lost_o
);
  localparam int unsigned BYTE_W = AW + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  ara_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              lost_q, lost_d;
  logic              scl_q;
  logic              win_q, win_d;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    lost_d  = lost_q;
    win_d   = 1'b0;
    case (state_q)
      ARA_IDLE: begin
        if (go_i && pend_i) begin
          state_d = ARA_SEND;
          cnt_d   = '0;
          lost_d  = 1'b0;
          sh_d    = {addr_i, 1'b1};
        end
      end
      ARA_SEND: begin
        // released for a 1 but bus reads 0: someone lower is talking
        if (scl_rise && sh_q[BYTE_W-1] && !sda_i) begin
          lost_d = 1'b1;
        end
        if (scl_fall) begin
          if (cnt_q == LAST) begin
            state_d = ARA_IDLE;
            win_d   = ~lost_q;
          end else begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
            cnt_d = CNT_W'(cnt_q + 1'b1);
          end
        end
      end
      default: state_d = ARA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARA_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      lost_q  <= 1'b0;
      scl_q   <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      lost_q  <= lost_d;
      scl_q   <= scl_i;
      win_q   <= win_d;
    end
  end

  assign busy_o    = (state_q == ARA_SEND);
  assign lost_o    = lost_q;
  assign win_o     = win_q;
  assign sda_low_o = busy_o & ~lost_q & ~sh_q[BYTE_W-1];
endmodule

// File: rtl/edge_alert_unit.sv
module edge_alert_unit
  import eia_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      line_i,
  input  logic [N-1:0]      rise_mask_i,
  input  logic [N-1:0]      fall_mask_i,
  input  logic              fault_i,
  input  logic              sw_reset_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ara_go_i,
  output logic              alert_n_o,
  output logic              sda_low_o
);
  logic [N-1:0] rise_evt, fall_evt;
  logic         irq_set, irq_pend;
  logic         ara_win, ara_busy, ara_lost;

  eia_edge_detect #(.N(N), .SYNC(SYNC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .rise_o (rise_evt),
    .fall_o (fall_evt)
  );

  eia_irq_latch #(.N(N)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise_evt),
    .fall_i      (fall_evt),
    .rise_mask_i (rise_mask_i),
    .fall_mask_i (fall_mask_i),
    .fault_i     (fault_i),
    .clr_sw_i    (sw_reset_i),
    .clr_win_i   (ara_win),
    .set_o       (irq_set),
    .pend_o      (irq_pend)
  );

  eia_ara_tx #(.AW(ADDR_W)) u_ara (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .go_i      (ara_go_i),
    .pend_i    (irq_pend),
    .addr_i    (own_addr_i),
    .sda_low_o (sda_low_o),
    .win_o     (ara_win),
    .busy_o    (ara_busy),
    .lost_o    (ara_lost)
  );

  assign alert_n_o = ~irq_pend;
endmodule

// File: rtl/edge_alert_unit_chk.sv
module edge_alert_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic alert_n_o,
  input logic sda_low_o,
  input logic scl_i,
  input logic fault_i,
  input logic sw_reset_i,
  input logic ara_go_i,
  input logic irq_set,
  input logic ara_win,
  input logic ara_busy,
  input logic ara_lost
);
  p_fault_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !alert_n_o);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n_o && !sw_reset_i && !ara_win) |=> !alert_n_o);

  p_swreset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_reset_i && !irq_set) |=> alert_n_o);

  p_win_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_win && !irq_set) |=> alert_n_o);

  p_set_beats_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !alert_n_o);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_go_i && alert_n_o && !ara_busy) |=> !sda_low_o);

  p_lost_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_lost && ara_busy) |=> (ara_lost || !ara_busy));

  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !scl_i);
endmodule

bind edge_alert_unit edge_alert_unit_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .alert_n_o  (alert_n_o),
  .sda_low_o  (sda_low_o),
  .scl_i      (scl_i),
  .fault_i    (fault_i),
  .sw_reset_i (sw_reset_i),
  .ara_go_i   (ara_go_i),
  .irq_set    (irq_set),
  .ara_win    (ara_win),
  .ara_busy   (ara_busy),
  .ara_lost   (ara_lost)
);

// File: tb/edge_alert_unit_tb_top.sv
`timescale 1ns/1ps
module edge_alert_unit_tb_top;
  localparam logic [6:0] MY_ADDR = 7'h25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line = '0, rmask = '1, fmask = '1;
  logic       fault = 1'b0, swr = 1'b0, go = 1'b0, scl = 1'b1, comp_rel = 1'b1;
  logic       alert_n, sda_low;
  wire        sda_bus = ~sda_low & comp_rel;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  edge_alert_unit dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .rise_mask_i(rmask),
    .fall_mask_i(fmask), .fault_i(fault), .sw_reset_i(swr),
    .own_addr_i(MY_ADDR), .scl_i(scl), .sda_i(sda_bus), .ara_go_i(go),
    .alert_n_o(alert_n), .sda_low_o(sda_low)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] h0, h1, h2;   // last three sampled line values, h0 newest
  int         seen;
  bit         m_pend, m_act, m_lost, m_sclp, m_win;
  int         m_bit;
  logic [7:0] m_byte;

  function automatic bit m_drive();
    return m_act && !m_lost && !m_byte[7 - m_bit];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0; seen = 0;
      m_pend = 0; m_act = 0; m_lost = 0; m_sclp = 0; m_win = 0; m_bit = 0;
      m_byte = '1;
    end else begin
      logic [7:0] up, dn;
      bit setv, nx_pend, nx_win, bus;
      up = (seen >= 3) ? (h1 & ~h2) : 8'h00;
      dn = (seen >= 3) ? (~h1 & h2) : 8'h00;
      setv = fault || |(up & ~rmask) || |(dn & ~fmask);
      nx_pend = setv ? 1'b1 : ((m_win || swr) ? 1'b0 : m_pend);
      bus = !m_drive() && comp_rel;
      nx_win = 0;
      if (!m_act) begin
        if (go && m_pend) begin
          m_act = 1; m_bit = 0; m_lost = 0; m_byte = {MY_ADDR, 1'b1};
        end
      end else begin
        if (scl && !m_sclp && m_byte[7 - m_bit] && !bus) m_lost = 1;
        if (!scl && m_sclp) begin
          if (m_bit == 7) begin m_act = 0; nx_win = !m_lost; end
          else m_bit++;
        end
      end
      m_sclp = scl;
      m_win = nx_win;
      m_pend = nx_pend;
      h2 = h1; h1 = h0; h0 = line;
      if (seen < 3) seen++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(alert_n == !m_pend, cur_req, "alert_n vs model", alert_n, !m_pend);
      check(sda_low == m_drive(), cur_req, "sda_low vs model", sda_low, m_drive());
    end
  end

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    report();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_sw();
    swr = 1; @(negedge clk); swr = 0; @(negedge clk);
  endtask

  // runs one alert-response byte; comp is the other talker's byte (FF = none)
  task automatic ara_byte(input logic [7:0] comp, output int drives);
    drives = 0;
    scl = 0; @(negedge clk);
    go = 1; @(negedge clk); go = 0;
    for (int i = 0; i < 8; i++) begin
      comp_rel = comp[7 - i];
      wait_cyc(2);
      scl = 1;
      drives += sda_low;
      wait_cyc(2);
      scl = 0;
    end
    wait_cyc(1);
    comp_rel = 1;
    wait_cyc(3);
    scl = 1;
    wait_cyc(1);
  endtask

  initial begin
    int d;
    // R1: reset state
    wait_cyc(3);
    check(alert_n == 1, "R1", "alert_n in reset", alert_n, 1);
    check(sda_low == 0, "R1", "sda_low in reset", sda_low, 0);
    rst_n = 1;
    wait_cyc(4);
    check(alert_n == 1, "R1", "alert_n after reset", alert_n, 1);

    // R2: rising edge latency
    cur_req = "R2";
    rmask = 8'hF7;
    line[3] = 1;
    @(negedge clk); check(alert_n == 1, "R2", "after edge k", alert_n, 1);
    @(negedge clk); check(alert_n == 1, "R2", "after edge k+1", alert_n, 1);
    @(negedge clk); check(alert_n == 0, "R2", "after edge k+2", alert_n, 0);

    // R8: software reset clears
    cur_req = "R8";
    swr = 1; @(negedge clk); swr = 0;
    check(alert_n == 1, "R8", "cleared by sw reset", alert_n, 1);
    wait_cyc(2);

    // R4: masked edges ignored on line 5
    cur_req = "R4";
    rmask = 8'hFF; fmask = 8'hFF;
    line[5] = 1; wait_cyc(4); line[5] = 0; wait_cyc(5);
    check(alert_n == 1, "R4", "masked edges ignored", alert_n, 1);

    // R3: falling edge on line 3
    cur_req = "R3";
    fmask = 8'hF7;
    line[3] = 0; wait_cyc(3);
    check(alert_n == 0, "R3", "fall sets flag", alert_n, 0);
    clear_sw();

    // R4: both masks open on line 1 flags both directions
    cur_req = "R4";
    rmask = 8'hFD; fmask = 8'hFD;
    line[1] = 1; wait_cyc(4);
    check(alert_n == 0, "R4", "both-edge rise", alert_n, 0);
    clear_sw(); wait_cyc(2);
    line[1] = 0; wait_cyc(4);
    check(alert_n == 0, "R4", "both-edge fall", alert_n, 0);
    clear_sw(); wait_cyc(2);

    // R5: one-cycle pulse on line 6, rise masked, fall enabled
    cur_req = "R5";
    rmask = 8'hFF; fmask = 8'hBF;
    line[6] = 1; @(negedge clk); line[6] = 0; wait_cyc(5);
    check(alert_n == 0, "R5", "pulse sets flag", alert_n, 0);

    // R6: masking afterwards does not clear
    cur_req = "R6";
    rmask = 8'hFF; fmask = 8'hFF;
    wait_cyc(10);
    check(alert_n == 0, "R6", "sticky after masking", alert_n, 0);

    // R9 + R11: won alert-response byte, address 0x25 -> 0100_1011 has 4 zeros
    cur_req = "R9";
    ara_byte(8'hFF, d);
    check(d == 4, "R9", "driven-low bits", d, 4);
    cur_req = "R11";
    check(alert_n == 1, "R11", "won byte clears flag", alert_n, 1);

    // R10: lose to address 0x24 (byte 0x49), flag stays, later win
    cur_req = "R10";
    rmask = 8'hF7; line[3] = 1; wait_cyc(4);
    rmask = 8'hFF;
    ara_byte(8'h49, d);
    check(d == 4, "R10", "drives before loss", d, 4);
    check(alert_n == 0, "R10", "flag kept after loss", alert_n, 0);
    ara_byte(8'hFF, d);
    check(alert_n == 1, "R10", "later win clears", alert_n, 1);

    // R12: go without pending interrupt
    cur_req = "R12";
    ara_byte(8'hFF, d);
    check(d == 0, "R12", "no drive when idle", d, 0);

    // R7: fault survives a won byte and sw reset
    cur_req = "R7";
    fault = 1; wait_cyc(2);
    check(alert_n == 0, "R7", "fault sets flag", alert_n, 0);
    ara_byte(8'hFF, d);
    check(alert_n == 0, "R7", "fault reasserts after win", alert_n, 0);
    clear_sw();
    check(alert_n == 0, "R7", "fault survives sw reset", alert_n, 0);
    fault = 0; wait_cyc(1); clear_sw();
    check(alert_n == 1, "R7", "clear after fault gone", alert_n, 1);

    // R13: transition reaches latch on the edge that samples sw reset
    cur_req = "R13";
    fmask = 8'hF7; line[3] = 0; wait_cyc(2);
    swr = 1; @(negedge clk); swr = 0;
    check(alert_n == 0, "R13", "set beats clear", alert_n, 0);
    wait_cyc(3);
    check(alert_n == 0, "R13", "still pending", alert_n, 0);
    clear_sw();
    wait_cyc(2);
    report();
  end
endmodule